// File: doc/BRIEF.md
# Serial 1011 Pattern Detector (one-hot, overlapping)

This block watches a one-bit serial stream, sampled on every rising clock edge, and raises a flag each time the last four sampled bits form the pattern 1, 0, 1, 1. A match may share bits with an earlier one. For example, the stream 1011011 produces two flags.

The controller is a Moore machine with five states. Each state has its own flip-flop:

| State | Meaning |
|---|---|
| `ST_IDLE` | no progress |
| `ST_GOT1` | "1" seen |
| `ST_GOT10` | "10" seen |
| `ST_GOT101` | "101" seen |
| `ST_HIT` | "1011" found |

Each next-state bit is a sum of products, read directly from the transition arcs:

- `ST_IDLE` is reached by a 0 from `ST_IDLE` or from `ST_GOT10`.
- `ST_GOT1` is reached by a 1 from `ST_IDLE`, `ST_GOT1` or `ST_HIT`.
- `ST_GOT10` is reached by a 0 from `ST_GOT1`, `ST_GOT101` or `ST_HIT`.
- `ST_GOT101` is reached by a 1 from `ST_GOT10`.
- `ST_HIT` is reached by a 1 from `ST_GOT101`.

The flag is the `ST_HIT` flop itself. It therefore changes only on clock edges.

An asynchronous, active-high reset sets the `ST_IDLE` flop and clears the other four.

Top module: `pattern_hit_detector`

## Requirements
- R1: While `arst_i` is 1, the state is `ST_IDLE` and `hit_o` is 0, at once and without a clock edge.
- R2: Exactly one of the five state flops is set at every clock edge after reset.
- R3: `hit_o` is 1 in the cycle that follows the edge sampling the final 1 of 1,0,1,1, and is 0 otherwise. Bits are sampled in arrival order and compared with the four most recent samples.
- R4: Detection never restarts from scratch. Overlapping matches are all flagged: 1011011 gives two flags and 10111011 gives two.
- R5: A 1 sampled in `ST_IDLE`, `ST_GOT1` or `ST_HIT` leads to `ST_GOT1`, so 11011 is flagged once.
- R6: A 0 sampled in `ST_GOT1`, `ST_GOT101` or `ST_HIT` leads to `ST_GOT10`, so 1010110 is flagged once.
- R7: A 0 sampled in `ST_IDLE` or `ST_GOT10` leads to `ST_IDLE`. A 1 in `ST_GOT10` leads to `ST_GOT101`, and a 1 in `ST_GOT101` leads to `ST_HIT`.
- R8: `hit_o` is never 1 for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge sampling clock |
| arst_i | input | 1 | Asynchronous active-high reset |
| bit_i | input | 1 | Serial data bit |
| hit_o | output | 1 | One-cycle pattern-found flag |

## Verification
The bench goes after overlapping streams such as 1011011, 10111011 and a long chain of four matches. A detector that restarted after each hit would drop the later flags. A stream of all ones and the case 11011 check that a repeated 1 holds the "1 seen" progress. A design that returned to `ST_IDLE` there would miss the match, and the bit-history model exposes it. An asynchronous reset is applied while the flag is high; a design with a synchronous reset would keep the flag high until the next edge. A long random stream compared cycle by cycle with a four-bit history catches any wrong arc, including arcs out of `ST_HIT` that would either lose progress or repeat the flag.

// File: rtl/det_pkg.sv
package det_pkg;
    localparam int unsigned ST_COUNT = 5;
    localparam int unsigned ST_IDX_W = $clog2(ST_COUNT);

    typedef enum logic [ST_IDX_W-1:0] {
        ST_IDLE   = 3'd0,
        ST_GOT1   = 3'd1,
        ST_GOT10  = 3'd2,
        ST_GOT101 = 3'd3,
        ST_HIT    = 3'd4
    } st_idx_e;

    typedef logic [ST_COUNT-1:0] onehot_t;

    localparam onehot_t RESET_VEC = onehot_t'(1) << ST_IDLE;
endpackage

// File: rtl/det_next_state.sv
module det_next_state
    import det_pkg::*;
(
    input  onehot_t cur_i,
    input  logic    bit_i,
    output onehot_t nxt_o
);
    // Each next-state bit is the OR of the arcs entering that state.
    always_comb begin
        nxt_o            = '0;
        nxt_o[ST_IDLE]   = ~bit_i & (cur_i[ST_IDLE] | cur_i[ST_GOT10]);
        nxt_o[ST_GOT1]   =  bit_i & (cur_i[ST_IDLE] | cur_i[ST_GOT1] | cur_i[ST_HIT]);
        nxt_o[ST_GOT10]  = ~bit_i & (cur_i[ST_GOT1] | cur_i[ST_GOT101] | cur_i[ST_HIT]);
        nxt_o[ST_GOT101] =  bit_i & cur_i[ST_GOT10];
        nxt_o[ST_HIT]    =  bit_i & cur_i[ST_GOT101];
    end
endmodule

// File: rtl/det_state_reg.sv
module det_state_reg
    import det_pkg::*;
(
    input  logic    clk_i,
    input  logic    arst_i,
    input  onehot_t nxt_i,
    output onehot_t st_o
);
    // One flop per state: the idle flop is preset, the others are cleared.
    for (genvar g = 0; g < ST_COUNT; g++) begin : g_flop
        always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i) st_o[g] <= RESET_VEC[g];
            else        st_o[g] <= nxt_i[g];
        end
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk_i) disable iff (arst_i)
        $onehot(st_o)); // R2
endmodule

// File: rtl/pattern_hit_detector.sv
module pattern_hit_detector
    import det_pkg::*;
(
    input  logic clk_i,
    input  logic arst_i,
    input  logic bit_i,
    output logic hit_o
);
    onehot_t st_q;
    onehot_t st_d;

    det_next_state i_next (
        .cur_i (st_q),
        .bit_i (bit_i),
        .nxt_o (st_d)
    );

    det_state_reg i_reg (
        .clk_i  (clk_i),
        .arst_i (arst_i),
        .nxt_i  (st_d),
        .st_o   (st_q)
    );

    // Moore output: taken straight from the final state flop.
    always_comb begin
        hit_o = st_q[ST_HIT];
    end

    AST_HIT_FROM_101: assert property (@(posedge clk_i) disable iff (arst_i)
        hit_o |-> ($past(st_q[ST_GOT101]) && $past(bit_i))); // R3

    AST_ONE_KEEPS_PROGRESS: assert property (@(posedge clk_i) disable iff (arst_i)
        ((st_q[ST_IDLE] || st_q[ST_GOT1] || st_q[ST_HIT]) && bit_i) |=> st_q[ST_GOT1]); // R5

    AST_ZERO_TO_10: assert property (@(posedge clk_i) disable iff (arst_i)
        ((st_q[ST_GOT1] || st_q[ST_GOT101] || st_q[ST_HIT]) && !bit_i) |=> st_q[ST_GOT10]); // R6

    AST_ZERO_TO_IDLE: assert property (@(posedge clk_i) disable iff (arst_i)
        ((st_q[ST_IDLE] || st_q[ST_GOT10]) && !bit_i) |=> st_q[ST_IDLE]); // R7

    AST_HIT_OVERLAP: assert property (@(posedge clk_i) disable iff (arst_i)
        (st_q[ST_GOT101] && bit_i) |=> hit_o); // R4

    AST_HIT_SINGLE: assert property (@(posedge clk_i) disable iff (arst_i)
        hit_o |=> !hit_o); // R8
endmodule

// File: tb/test_pattern_hit_detector.sv
`timescale 1ns/100ps
module test_pattern_hit_detector;
    logic clk = 1'b0;
    logic arst = 1'b1;
    logic din = 1'b0;
    logic hit;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] hist = '0;
    logic       prev_hit = 1'b0;
    int         hit_cnt = 0;

    always #2.5 clk = ~clk;

    pattern_hit_detector i_pattern_hit_detector (
        .clk_i  (clk),
        .arst_i (arst),
        .bit_i  (din),
        .hit_o  (hit)
    );

    typedef struct packed {
        logic [4:0]  len;
        logic [15:0] bits;   // first bit sent is bits[len-1]
        logic [3:0]  hits;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{5'd7,  16'b1011011,          4'd2},  // R4
        '{5'd8,  16'b10111011,         4'd2},  // R4
        '{5'd5,  16'b11011,            4'd1},  // R5
        '{5'd7,  16'b1010110,          4'd1},  // R6
        '{5'd6,  16'b000000,           4'd0},  // R7
        '{5'd6,  16'b111111,           4'd0},  // R5
        '{5'd14, 16'b10110110111011,   4'd4},  // R4
        '{5'd4,  16'b1011,             4'd1}   // R3
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        arst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        arst = 1'b0;
        hist = '0;
        prev_hit = 1'b0;
    endtask

    // Called at a negative edge: drive, let one rising edge sample, check at next negedge.
    task automatic step(input logic b, input string req);
        logic exp_hit;
        din = b;
        @(negedge clk);
        hist = {hist[2:0], b};
        exp_hit = (hist == 4'b1011);
        check(hit === exp_hit, req, int'(hit), int'(exp_hit));
        check(!(prev_hit && hit), "R8", int'(hit), 0);
        if (hit) hit_cnt++;
        prev_hit = hit;
    endtask

    initial begin
        #(200_000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: output low during reset
        @(negedge clk);
        check(hit === 1'b0, "R1", int'(hit), 0);
        do_reset();
        check(hit === 1'b0, "R1", int'(hit), 0);

        // Vector table, walked by one loop (R3 R4 R5 R6 R7)
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            hit_cnt = 0;
            for (int i = int'(VECS[v].len) - 1; i >= 0; i--)
                step(VECS[v].bits[i], "R3");
            check(hit_cnt == int'(VECS[v].hits), "R4", hit_cnt, int'(VECS[v].hits));
        end

        // R1: asynchronous reset while flag high, checked between edges
        do_reset();
        step(1'b1, "R3"); step(1'b0, "R3"); step(1'b1, "R3"); step(1'b1, "R3");
        check(hit === 1'b1, "R3", int'(hit), 1);
        #1 arst = 1'b1;
        #0.5;
        check(hit === 1'b0, "R1", int'(hit), 0);
        @(negedge clk);
        check(hit === 1'b0, "R1", int'(hit), 0);
        arst = 1'b0;
        hist = '0;
        prev_hit = 1'b0;
        // After reset, a lone "011" must not complete a match (R7 idle start)
        step(1'b0, "R7"); step(1'b1, "R7"); step(1'b1, "R7");

        // Random stream against the history model (R2 R3 R6)
        do_reset();
        for (int i = 0; i < 2000; i++)
            step(1'($urandom_range(0, 1)), "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule